// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is a watchdog timer sitting on a simple 16-bit register bus. Software has to place a register-specific key in the top byte of every write, and any write without the right key is dropped. A selectable power-of-two prescaler advances an 8-bit up-counter. When the counter wraps past 255, the block raises a sticky overflow flag. If the reset enable and watchdog mode are both set, it also drives a reset pulse of fixed length.

Software keeps the watchdog alive by writing the reload value to the counter before it wraps. Loading 256 minus N gives N prescaled ticks before overflow. The overflow flag is protected against a stray clear: the clear code only works after software has read the flag while it was set.

Top module: `key_wdt`

## Requirements
- R1: After reset every register reads 0x0000 and `wdt_rst_o` is low.
- R2: A write to byte address 0 is honoured only when bits 15:8 equal 0xA5. It then loads enable from bit 5, watchdog mode from bit 6 and the clock-select code from the low CKS_W bits. Reads of address 0 return these fields in the same bit positions, with the upper byte zero.
- R3: A write to address 2 is honoured only when bits 15:8 equal 0x5A. It then loads bits 7:0 into the counter. Reading address 2 returns the counter in bits 7:0.
- R4: A write to address 4 with key 0x5A in bits 15:8 loads the reset enable from bit 6. The overflow flag reads at bit 7 of address 4 and cannot be set by a write. A write to address 4 with any other key, except the clear code, has no effect.
- R5: A clock-select code c divides the clock by 2^(1 + c*(E-1)/(2^CKS_W-1)), with E = 22 for a 4-bit field and E = 14 for a 3-bit field. Take the case where the counter is loaded with 0xFE and reset is enabled. From the cycle the enabling control write is accepted, `wdt_rst_o` rises 4 cycles later at code 0 and 8 cycles later at code 1.
- R6: Each prescaler tick adds one to the counter. A tick at 255 wraps it to 0 and sets the sticky overflow flag. Loading 0xFF makes the first tick overflow, so reset rises 2 cycles after enable at code 0.
- R7: Writing exactly 0xA500 to address 4 clears the overflow flag only if address 4 was read while the flag was set. Otherwise it has no effect.
- R8: On overflow with reset enable and watchdog mode both set, `wdt_rst_o` is high for exactly 16 clock cycles. With either bit clear, it stays low.
- R9: While the enable bit is clear, the counter holds its value.
- R10: A counter write restarts the prescaler. Reloading the counter every 2 cycles at code 1 therefore prevents any overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_addr_i | input | 3 | Byte address (0, 2 or 4) |
| bus_wdata_i | input | 16 | Write data, key in bits 15:8 |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| wdt_rst_o | output | 1 | Reset pulse on overflow |

## Verification
The hardest situation to reach from the ports is the flag-clear handshake. The clear code must be refused while the flag is set but has not yet been read, and that condition exists only in a narrow window after an overflow. The stimulus forces an overflow with a counter preload of 0xFE or 0xFF at the fastest divider. It stops the timer, then sends the clear code before any read of address 4. Only after that does it read the flag and clear it again. Reset-pulse timing is pinned by counting cycles from the enabling write to the rising edge of `wdt_rst_o`, at two divider codes.

// File: rtl/key_wdt_pkg.sv
package key_wdt_pkg;

    localparam int CKS_MAX_W = 4;
    localparam int CNT_W     = 8;
    localparam int DATA_W    = 16;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_CNT  = 3'd2;
    localparam logic [2:0] ADDR_RSC  = 3'd4;

    localparam logic [7:0]  KEY_CTRL  = 8'hA5;
    localparam logic [7:0]  KEY_CNT   = 8'h5A;
    localparam logic [7:0]  KEY_RSC   = 8'h5A;
    localparam logic [15:0] CLR_CODE  = 16'hA500;

    typedef struct packed {
        logic                 en;
        logic                 wt;
        logic [CKS_MAX_W-1:0] cks;
        logic [CNT_W-1:0]     cnt;
        logic                 rste;
        logic                 ovf;
        logic                 seen;
    } wdt_state_t;

    // largest divider exponent for a given select width
    function automatic int unsigned max_exp(input int unsigned cks_w);
        return (cks_w == 4) ? 22 : 14;
    endfunction

    // divider exponent for a select code
    function automatic int unsigned div_exp(input logic [CKS_MAX_W-1:0] code,
                                            input int unsigned cks_w);
        int unsigned top_code;
        top_code = (1 << cks_w) - 1;
        return 1 + (int'(code) * (max_exp(cks_w) - 1)) / top_code;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import key_wdt_pkg::*;
#(
    parameter int CKS_W = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 run_i,
    input  logic                 clr_i,
    input  logic [CKS_MAX_W-1:0] code_i,
    output logic                 tick_o
);
    localparam int PRE_W = max_exp(CKS_W);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask   = (PRE_W'(1) << div_exp(code_i, CKS_W)) - PRE_W'(1);
        tick_o = run_i && !clr_i && ((pre_q & mask) == mask);
        if (clr_i || !run_i) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    output logic pulse_o
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (fire_i) begin
            left_d = PW'(PULSE_LEN);
        end else if (left_q != '0) begin
            left_d = left_q - PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end

    assign pulse_o = (left_q != '0);
endmodule

// File: rtl/key_wdt.sv
module key_wdt
    import key_wdt_pkg::*;
#(
    parameter int CKS_W     = 4,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              wdt_rst_o
);
    localparam logic [CKS_MAX_W-1:0] CKS_MASK = CKS_MAX_W'((1 << CKS_W) - 1);

    wdt_state_t st_d, st_q;
    logic       tick;
    logic       pre_clr;
    logic       fire;
    logic       ctrl_hit, cnt_hit, rsc_hit, clr_hit;

    wdt_prescaler #(.CKS_W(CKS_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (st_q.en),
        .clr_i  (pre_clr),
        .code_i (st_q.cks),
        .tick_o (tick)
    );

    wdt_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fire_i  (fire),
        .pulse_o (wdt_rst_o)
    );

    always_comb begin
        st_d    = st_q;
        fire    = 1'b0;
        ctrl_hit = bus_wr_i && (bus_addr_i == ADDR_CTRL) && (bus_wdata_i[15:8] == KEY_CTRL);
        cnt_hit  = bus_wr_i && (bus_addr_i == ADDR_CNT)  && (bus_wdata_i[15:8] == KEY_CNT);
        clr_hit  = bus_wr_i && (bus_addr_i == ADDR_RSC)  && (bus_wdata_i == CLR_CODE);
        rsc_hit  = bus_wr_i && (bus_addr_i == ADDR_RSC)  && (bus_wdata_i[15:8] == KEY_RSC);
        pre_clr  = cnt_hit;

        if (ctrl_hit) begin
            st_d.en  = bus_wdata_i[5];
            st_d.wt  = bus_wdata_i[6];
            st_d.cks = bus_wdata_i[CKS_MAX_W-1:0] & CKS_MASK;
        end

        // a read of the set flag arms the clear
        if (bus_rd_i && (bus_addr_i == ADDR_RSC) && st_q.ovf) begin
            st_d.seen = 1'b1;
        end

        if (clr_hit) begin
            if (st_q.seen) begin
                st_d.ovf  = 1'b0;
                st_d.seen = 1'b0;
            end
        end else if (rsc_hit) begin
            st_d.rste = bus_wdata_i[6];
        end

        // counter write wins over a tick in the same cycle
        if (cnt_hit) begin
            st_d.cnt = bus_wdata_i[CNT_W-1:0];
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == '1) begin
                st_d.ovf = 1'b1;
                fire     = st_q.rste && st_q.wt;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_addr_i)
            ADDR_CTRL: bus_rdata_o = {8'h00, 1'b0, st_q.wt, st_q.en, 1'b0, st_q.cks};
            ADDR_CNT:  bus_rdata_o = {8'h00, st_q.cnt};
            ADDR_RSC:  bus_rdata_o = {8'h00, st_q.ovf, st_q.rste, 6'b000000};
            default:   bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/key_wdt_chk.sv
module key_wdt_chk
    import key_wdt_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_wr_i,
    input logic [2:0]        bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              wdt_rst_o,
    input wdt_state_t        st
);
    localparam int RW = $clog2(PULSE_LEN + 2);

    logic [RW-1:0] hi_run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_run <= '0;
        end else if (wdt_rst_o) begin
            hi_run <= hi_run + RW'(1);
        end else begin
            hi_run <= '0;
        end
    end

    // R2
    bad_ctrl_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == ADDR_CTRL && bus_wdata_i[15:8] != KEY_CTRL)
        |=> ($stable(st.en) && $stable(st.wt) && $stable(st.cks)));

    // R9
    stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st.en && !(bus_wr_i && bus_addr_i == ADDR_CNT && bus_wdata_i[15:8] == KEY_CNT))
        |=> $stable(st.cnt));

    // R7
    flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st.ovf) |-> $past(bus_wr_i && bus_addr_i == ADDR_RSC
                                && bus_wdata_i == CLR_CODE && st.seen));

    // R8
    rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wdt_rst_o) |-> ($past(st.rste && st.wt) && st.ovf));

    // R8
    pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(wdt_rst_o) |-> (hi_run == RW'(PULSE_LEN)));

    // R8
    pulse_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hi_run <= RW'(PULSE_LEN));
endmodule

bind key_wdt key_wdt_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .wdt_rst_o   (wdt_rst_o),
    .st          (st_q)
);

// File: tb/tb_key_wdt.sv
`timescale 1ns/1ps
module tb_key_wdt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic        peek = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rst_o;

    int vectors = 0;
    int fails = 0;
    int hi_cnt = 0;
    logic [15:0] exp_q[$];
    string       req_q[$];
    logic [15:0] peek_val;

    always #2 clk = ~clk;

    key_wdt dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .wdt_rst_o(rst_o)
    );

    // monitor: compares read data against the scoreboard
    always @(negedge clk) begin
        if (rst_o) hi_cnt++;
        if (rd && !peek) begin
            logic [15:0] e;
            string r;
            if (exp_q.size() == 0) begin
                e = 16'hxxxx;
                r = "unexpected";
            end else begin
                e = exp_q.pop_front();
                r = req_q.pop_front();
            end
            vectors++;
            if (rdata !== e) begin
                fails++;
                $display("FAIL %s: read addr %0d actual %h expected %h", r, addr, rdata, e);
            end
        end else if (rd && peek) begin
            peek_val = rdata;
        end
    end

    task automatic chk(input int act, input int expv, input string req);
        vectors++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, input logic [15:0] e, input string req);
        @(posedge clk); #1;
        rd = 1'b1; addr = a;
        exp_q.push_back(e); req_q.push_back(req);
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic bus_peek(input logic [2:0] a, output logic [15:0] v);
        @(posedge clk); #1;
        rd = 1'b1; peek = 1'b1; addr = a;
        @(posedge clk); #1;
        rd = 1'b0; peek = 1'b0;
        v = peek_val;
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        while (n < 60) begin
            @(posedge clk); #1;
            n++;
            if (rst_o) break;
        end
    endtask

    task automatic pulse_width(output int w);
        w = 0;
        while (rst_o && w < 100) begin
            w++;
            @(posedge clk); #1;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int n;
        int w;
        int h0;
        logic [15:0] a;
        idle(3);
        #1 rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk(rst_o, 0, "R1 reset output");
        bus_rd(3'd0, 16'h0000, "R1 ctrl");
        bus_rd(3'd2, 16'h0000, "R1 counter");
        bus_rd(3'd4, 16'h0000, "R1 rsc");

        // R2 keyed control write
        bus_wr(3'd0, 16'h0060);
        bus_rd(3'd0, 16'h0000, "R2 bad key ignored");
        bus_wr(3'd0, 16'hA54F);
        bus_rd(3'd0, 16'h004F, "R2 fields");
        bus_wr(3'd0, 16'hA500);

        // R3 keyed counter write
        bus_wr(3'd2, 16'hA512);
        bus_rd(3'd2, 16'h0000, "R3 bad key ignored");
        bus_wr(3'd2, 16'h5AF0);
        bus_rd(3'd2, 16'h00F0, "R3 load");
        idle(10);
        bus_rd(3'd2, 16'h00F0, "R9 held while disabled");

        // R4 reset enable, ovf not writable
        bus_wr(3'd4, 16'h5AC0);
        bus_rd(3'd4, 16'h0040, "R4 rste set, ovf not writable");
        bus_wr(3'd4, 16'h1200);
        bus_rd(3'd4, 16'h0040, "R4 bad key ignored");

        // R5/R8 code 0
        bus_wr(3'd2, 16'h5AFE);
        bus_wr(3'd0, 16'hA560);
        wait_rise(n);
        chk(n, 4, "R5 code0 reset latency");
        pulse_width(w);
        chk(w, 16, "R8 pulse width");
        bus_wr(3'd0, 16'hA500);

        // R7 clear without read is refused
        bus_wr(3'd4, 16'hA500);
        bus_rd(3'd4, 16'h00C0, "R7 unread clear ignored");
        bus_wr(3'd4, 16'hA500);
        bus_rd(3'd4, 16'h0040, "R7 clear after read");

        // R5 code 1
        bus_wr(3'd2, 16'h5AFE);
        bus_wr(3'd0, 16'hA561);
        wait_rise(n);
        chk(n, 8, "R5 code1 reset latency");
        pulse_width(w);
        chk(w, 16, "R8 pulse width code1");
        bus_wr(3'd0, 16'hA500);
        bus_rd(3'd4, 16'h00C0, "R6 flag sticky");
        bus_wr(3'd4, 16'hA500);
        bus_rd(3'd4, 16'h0040, "R7 clear");

        // R6 single tick from 0xFF
        bus_wr(3'd2, 16'h5AFF);
        bus_wr(3'd0, 16'hA560);
        wait_rise(n);
        chk(n, 2, "R6 single tick");
        pulse_width(w);
        bus_wr(3'd0, 16'hA500);
        bus_rd(3'd4, 16'h00C0, "R6 flag set");
        bus_wr(3'd4, 16'hA500);

        // R8 no reset when rste clear
        bus_wr(3'd4, 16'h5A00);
        bus_rd(3'd4, 16'h0000, "R4 rste cleared");
        h0 = hi_cnt;
        bus_wr(3'd2, 16'h5AFE);
        bus_wr(3'd0, 16'hA560);
        idle(30);
        chk(hi_cnt - h0, 0, "R8 no reset without rste");
        bus_wr(3'd0, 16'hA500);
        bus_rd(3'd4, 16'h0080, "R6 flag set without reset");
        bus_wr(3'd4, 16'hA500);

        // R8 no reset outside watchdog mode
        bus_wr(3'd4, 16'h5A40);
        h0 = hi_cnt;
        bus_wr(3'd2, 16'h5AFE);
        bus_wr(3'd0, 16'hA520);
        idle(30);
        chk(hi_cnt - h0, 0, "R8 no reset without wt");
        bus_wr(3'd0, 16'hA500);
        bus_rd(3'd0, 16'h0000, "R2 stop write");
        bus_rd(3'd4, 16'h00C0, "R6 flag in timer mode");
        bus_wr(3'd4, 16'hA500);

        // R10 kicking
        h0 = hi_cnt;
        bus_wr(3'd2, 16'h5AFE);
        bus_wr(3'd0, 16'hA561);
        for (int k = 0; k < 25; k++) bus_wr(3'd2, 16'h5AFE);
        chk(hi_cnt - h0, 0, "R10 kicks prevent reset");
        bus_wr(3'd0, 16'hA500);
        bus_rd(3'd2, 16'h00FE, "R10 counter at reload");
        bus_rd(3'd4, 16'h0040, "R10 no overflow");

        // R9 stop holds count, R6 counting
        bus_wr(3'd2, 16'h5A10);
        bus_wr(3'd0, 16'hA560);
        idle(9);
        bus_wr(3'd0, 16'hA500);
        bus_peek(3'd2, a);
        chk((a > 16'h0010) ? 1 : 0, 1, "R6 counter advanced");
        idle(20);
        bus_rd(3'd2, a, "R9 counter held after stop");

        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule